// File: doc/BRIEF.md
# Symbol-to-Chip Spreading Transmitter

This block is the digital front of a 2.4 GHz direct-sequence transmitter. The host loads a frame into a private 128-byte transmit buffer and pulses a start strobe. The block then builds the on-air frame by itself. It sends a run of all-zero preamble bytes, then a fixed start-of-frame delimiter byte, then the length byte taken from the buffer, then as many payload bytes as that length names.

Each byte becomes two 4-bit symbols, and each symbol becomes a 32-chip pseudo-noise word. One chip leaves per chip-enable tick. Chips with an even index go to the in-phase output and chips with an odd index go to the quadrature output, which suits an offset-QPSK modulator that follows.

If the buffer runs dry before the frame is complete, the frame is cut short and a sticky underflow flag is raised. A single-cycle done pulse marks the end of every frame.

Top module: `zbs_spread_tx`

## Requirements
- R1: The transmit buffer holds 128 bytes. `fifo_full` is 1 while it holds 128 bytes. A write while full is dropped and changes nothing.
- R2: A `start` pulse while idle begins a frame, and `busy` is 1 in the next cycle. A `start` while busy has no effect on the frame in progress.
- R3: Every frame opens with 4 bytes of 0x00 and then the byte 0xA7, all generated internally and none taken from the buffer.
- R4: After 0xA7 the first buffer byte is sent as the length L, followed by L more buffer bytes. A complete frame therefore emits exactly 64*(6+L) chips.
- R5: Within a byte the low nibble (bits 3:0) is sent before the high nibble (bits 7:4).
- R6: Symbol 0 is the chip word 11011001110000110101001000101110, with chip 0 leftmost. Symbol s in 1..7 is symbol 0 rotated right by 4*s chip positions. Symbol s in 8..15 is symbol s-8 with every odd-indexed chip inverted. Chips are sent in index order 0..31.
- R7: Exactly one chip is emitted per `chip_en` cycle while busy, and `chip_valid`/`chip_bit` appear in the cycle after that `chip_en`. No chip is emitted without a tick.
- R8: On a chip with an even index, `chip_i` takes the chip value and `chip_q` holds its value. On an odd index, `chip_q` takes the chip value and `chip_i` holds. Both outputs hold between chips.
- R9: If the buffer is empty when the length byte or a payload byte is needed, the frame ends after the last complete byte and `underflow` becomes 1. It stays 1 until the next frame starts.
- R10: `done` is a one-cycle pulse in the same cycle as the last `chip_valid` of the frame, and `busy` is 0 in that cycle.
- R11: After reset `busy`, `done`, `underflow`, `chip_valid`, `chip_bit`, `chip_i`, `chip_q` and `fifo_full` are all 0, and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one byte into the transmit buffer |
| wr_data | input | 8 | Byte to write |
| fifo_full | output | 1 | Buffer holds 128 bytes |
| start | input | 1 | Begin a frame (taken only while idle) |
| chip_en | input | 1 | Chip-rate tick; one chip per high cycle |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| underflow | output | 1 | Last frame ran out of buffer data (sticky) |
| chip_valid | output | 1 | A chip was emitted this cycle |
| chip_bit | output | 1 | Serial chip value |
| chip_i | output | 1 | In-phase chip (even indices) |
| chip_q | output | 1 | Quadrature chip (odd indices) |

## Verification
A wrong chip counter or symbol select shows up on `chip_bit` within one symbol period (32 ticks) as a chip that differs from the expected pseudo-noise word. A wrong nibble or byte stage shows up within 64 ticks, at the first byte after the fault, and a preamble fault appears in the very first symbol. Errors in the length or buffer-pointer state show up only at the frame's end, as a chip total other than 64*(6+L) or as a wrong `underflow`. A byte wrongly kept or dropped by the buffer is exposed by the next frame, which then reads a different length byte or ends early.

// File: rtl/zbs_pkg.sv
package zbs_pkg;

   localparam int CHIPS_PER_SYM = 32;
   localparam int CIDX_W        = $clog2(CHIPS_PER_SYM);

   // Chip word of symbol zero; bit 31 holds chip 0.
   localparam logic [31:0] BASE_WORD = 32'hD9C3522E;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_SFD,
      ST_LEN,
      ST_PAY
   } stage_e;

   // Chip k of symbol sym: rotation by 4*sym[2:0], odd chips flipped when sym[3].
   function automatic logic chip_of(input logic [3:0] sym, input logic [CIDX_W-1:0] k);
      logic [CIDX_W-1:0] j;
      logic              c;
      j = k - {sym[2:0], 2'b00};
      c = BASE_WORD[5'd31 - j];
      if (sym[3] && k[0]) c = ~c;
      return c;
   endfunction

endpackage

// File: rtl/zbs_tx_fifo.sv
module zbs_tx_fifo #(
   parameter int DEPTH = 128,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full
);
   localparam int AW   = $clog2(DEPTH);
   localparam bit POW2 = (DEPTH == (1 << AW));

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [AW:0]   count;
   logic          do_wr, do_rd;

   assign full  = (count == (AW+1)'(DEPTH));
   assign empty = (count == '0);
   assign do_wr = wr_en & ~full;
   assign do_rd = rd_en & ~empty;

   generate
      if (POW2) begin : g_wrap
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_cmp
         assign wr_nxt = (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr] <= wr_data;
   end

   // Show-ahead read: head byte is visible before the pop.
   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_nxt;
         if (do_rd) rd_ptr <= rd_nxt;
         case ({do_wr, do_rd})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/zbs_frame_seq.sv
module zbs_frame_seq
   import zbs_pkg::*;
#(
   parameter int         PRE_BYTES = 4,
   parameter logic [7:0] SFD_VAL   = 8'hA7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              chip_en,
   input  logic              fifo_empty,
   input  logic [7:0]        fifo_data,
   output logic              fifo_pop,
   output logic              emit,
   output logic [3:0]        sym,
   output logic [CIDX_W-1:0] chip_idx,
   output logic              busy,
   output logic              done,
   output logic              underflow
);
   localparam int PW = $clog2(PRE_BYTES + 1);

   stage_e      stage;
   logic [7:0]  cur_byte;
   logic [7:0]  remaining;
   logic [PW-1:0] pre_cnt;
   logic        nib;
   logic        byte_end;
   logic        want_byte;

   assign busy     = (stage != ST_IDLE);
   assign emit     = busy & chip_en;
   assign sym      = nib ? cur_byte[7:4] : cur_byte[3:0];
   assign byte_end = emit && (chip_idx == CIDX_W'(CHIPS_PER_SYM-1)) && nib;

   always_comb begin
      want_byte = 1'b0;
      if (byte_end) begin
         if (stage == ST_SFD) want_byte = 1'b1;
         else if ((stage == ST_LEN || stage == ST_PAY) && remaining != 8'd0) want_byte = 1'b1;
      end
   end
   assign fifo_pop = want_byte & ~fifo_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage     <= ST_IDLE;
         cur_byte  <= '0;
         remaining <= '0;
         pre_cnt   <= '0;
         nib       <= 1'b0;
         chip_idx  <= '0;
         done      <= 1'b0;
         underflow <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && stage == ST_IDLE) begin
            stage     <= ST_PRE;
            cur_byte  <= 8'h00;
            pre_cnt   <= '0;
            nib       <= 1'b0;
            chip_idx  <= '0;
            underflow <= 1'b0;
         end else if (emit) begin
            chip_idx <= chip_idx + 1'b1;
            if (chip_idx == CIDX_W'(CHIPS_PER_SYM-1)) begin
               nib <= ~nib;
               if (nib) begin
                  case (stage)
                     ST_PRE: begin
                        if (pre_cnt == PW'(PRE_BYTES-1)) begin
                           stage    <= ST_SFD;
                           cur_byte <= SFD_VAL;
                        end else begin
                           pre_cnt  <= pre_cnt + 1'b1;
                           cur_byte <= 8'h00;
                        end
                     end
                     ST_SFD: begin
                        if (fifo_empty) begin
                           stage     <= ST_IDLE;
                           underflow <= 1'b1;
                           done      <= 1'b1;
                        end else begin
                           stage     <= ST_LEN;
                           cur_byte  <= fifo_data;
                           remaining <= fifo_data;
                        end
                     end
                     ST_LEN, ST_PAY: begin
                        if (remaining == 8'd0) begin
                           stage <= ST_IDLE;
                           done  <= 1'b1;
                        end else if (fifo_empty) begin
                           stage     <= ST_IDLE;
                           underflow <= 1'b1;
                           done      <= 1'b1;
                        end else begin
                           stage     <= ST_PAY;
                           cur_byte  <= fifo_data;
                           remaining <= remaining - 1'b1;
                        end
                     end
                     default: stage <= ST_IDLE;
                  endcase
               end
            end
         end
      end
   end
endmodule

// File: rtl/zbs_chip_out.sv
module zbs_chip_out
   import zbs_pkg::*;
#(
   parameter bit IQ_SWAP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              emit,
   input  logic [3:0]        sym,
   input  logic [CIDX_W-1:0] chip_idx,
   output logic              chip_valid,
   output logic              chip_bit,
   output logic              chip_i,
   output logic              chip_q
);
   logic c;
   logic to_q;

   assign c = chip_of(sym, chip_idx);

   generate
      if (IQ_SWAP) begin : g_swap
         assign to_q = ~chip_idx[0];
      end else begin : g_norm
         assign to_q = chip_idx[0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chip_valid <= 1'b0;
         chip_bit   <= 1'b0;
         chip_i     <= 1'b0;
         chip_q     <= 1'b0;
      end else begin
         chip_valid <= emit;
         if (emit) begin
            chip_bit <= c;
            if (to_q) chip_q <= c;
            else      chip_i <= c;
         end
      end
   end
endmodule

// File: rtl/zbs_spread_tx.sv
module zbs_spread_tx
   import zbs_pkg::*;
#(
   parameter int         FIFO_DEPTH = 128,
   parameter int         PRE_BYTES  = 4,
   parameter logic [7:0] SFD_VAL    = 8'hA7,
   parameter bit         IQ_SWAP    = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   output logic       fifo_full,
   input  logic       start,
   input  logic       chip_en,
   output logic       busy,
   output logic       done,
   output logic       underflow,
   output logic       chip_valid,
   output logic       chip_bit,
   output logic       chip_i,
   output logic       chip_q
);
   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 2");
      end
      if (PRE_BYTES < 1) begin : g_bad_pre
         $error("PRE_BYTES must be at least 1");
      end
   endgenerate

   logic              f_empty, f_pop, emit;
   logic [7:0]        f_data;
   logic [3:0]        sym;
   logic [CIDX_W-1:0] chip_idx;

   zbs_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) fifo_u (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (f_pop),
      .rd_data (f_data),
      .empty   (f_empty),
      .full    (fifo_full)
   );

   zbs_frame_seq #(.PRE_BYTES(PRE_BYTES), .SFD_VAL(SFD_VAL)) seq_u (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .chip_en    (chip_en),
      .fifo_empty (f_empty),
      .fifo_data  (f_data),
      .fifo_pop   (f_pop),
      .emit       (emit),
      .sym        (sym),
      .chip_idx   (chip_idx),
      .busy       (busy),
      .done       (done),
      .underflow  (underflow)
   );

   zbs_chip_out #(.IQ_SWAP(IQ_SWAP)) out_u (
      .clk        (clk),
      .rst_n      (rst_n),
      .emit       (emit),
      .sym        (sym),
      .chip_idx   (chip_idx),
      .chip_valid (chip_valid),
      .chip_bit   (chip_bit),
      .chip_i     (chip_i),
      .chip_q     (chip_q)
   );
endmodule

// File: rtl/zbs_spread_tx_chk.sv
module zbs_spread_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic chip_en,
   input logic busy,
   input logic done,
   input logic underflow,
   input logic chip_valid,
   input logic chip_i,
   input logic chip_q
);
   assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_chip_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      chip_valid |-> $past(chip_en));

   assert_no_chip_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      chip_valid |-> (busy || done));

   assert_iq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_valid |-> ($stable(chip_i) && $stable(chip_q)));

   assert_iq_one_side_R8: assert property (@(posedge clk) disable iff (!rst_n)
      chip_valid |-> ($stable(chip_i) || $stable(chip_q)));

   assert_uflow_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underflow) |-> done);

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && chip_valid));
endmodule

bind zbs_spread_tx zbs_spread_tx_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .chip_en    (chip_en),
   .busy       (busy),
   .done       (done),
   .underflow  (underflow),
   .chip_valid (chip_valid),
   .chip_i     (chip_i),
   .chip_q     (chip_q)
);

// File: tb/zbs_spread_tx_tb_top.sv
`timescale 1ns/1ps
module zbs_spread_tx_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       start = 1'b0;
   logic       chip_en = 1'b0;
   logic       fifo_full, busy, done, underflow, chip_valid, chip_bit, chip_i, chip_q;

   int n_chk = 0;
   int n_bad = 0;
   int wd    = 0;
   bit ended = 1'b0;
   int exp_b[$];

   localparam string SEQ0 = "11011001110000110101001000101110";

   // length, seed, chip_en period, cycle to poke start (-1 none)
   localparam int NVEC = 5;
   localparam int VEC [0:NVEC-1][0:3] = '{
      '{0,  8'h00, 1, -1},
      '{3,  8'h10, 1, 40},
      '{5,  8'hF7, 3, 600},
      '{16, 8'h3C, 2, -1},
      '{2,  8'h8E, 1, 300}
   };

   always #2.5 clk = ~clk;

   zbs_spread_tx dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .fifo_full(fifo_full),
      .start(start), .chip_en(chip_en), .busy(busy), .done(done), .underflow(underflow),
      .chip_valid(chip_valid), .chip_bit(chip_bit), .chip_i(chip_i), .chip_q(chip_q)
   );

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd == 190000 && !ended) begin
         ended = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=%0d cycles expected=<190000", wd);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit exp_chip(input int s, input int k);
      int j;
      bit c;
      j = (k - 4 * (s % 8) + 64) % 32;
      c = (SEQ0[j] == 8'h31);
      if (s >= 8 && (k % 2) == 1) c = !c;
      return c;
   endfunction

   task automatic push(input int b);
      wr_en   = 1'b1;
      wr_data = b[7:0];
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic head();
      exp_b.delete();
      for (int i = 0; i < 4; i++) exp_b.push_back(0);
      exp_b.push_back(8'hA7);
   endtask

   task automatic run_frame(input int period, input int poke_at, input bit exp_uf, input string tag);
      int n = 0, bad_pre = 0, bad = 0, iq_bad = 0, tick_bad = 0;
      int total;
      int lim;
      bit seen_done = 1'b0;
      total = 64 * exp_b.size();
      lim   = total * period + 200;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
      chk(underflow === 1'b0, "R9 underflow cleared by start", int'(underflow), 0);
      for (int cyc = 0; cyc < lim; cyc++) begin
         chip_en = ((cyc % period) == 0);
         start   = (cyc == poke_at);
         @(negedge clk);
         if (chip_valid) begin
            if (!chip_en) tick_bad++;
            if (n < total) begin
               int by, sv, k;
               bit e;
               by = exp_b[n / 64];
               sv = ((n / 32) % 2 == 1) ? (by >> 4) & 15 : by & 15;
               k  = n % 32;
               e  = exp_chip(sv, k);
               if (chip_bit !== e) begin
                  if (n < 320) bad_pre++;
                  else bad++;
               end
               if ((k % 2 == 0 && chip_i !== e) || (k % 2 == 1 && chip_q !== e)) iq_bad++;
            end
            n++;
         end
         if (done) begin
            seen_done = 1'b1;
            chk(busy === 1'b0, "R10 busy low with done", int'(busy), 0);
            break;
         end
      end
      chip_en = 1'b0;
      start   = 1'b0;
      $display("frame %s: %0d chips", tag, n);
      chk(bad_pre == 0, "R3 preamble and delimiter chips", bad_pre, 0);
      chk(bad == 0, "R5 R6 data chips", bad, 0);
      chk(iq_bad == 0, "R8 I/Q split", iq_bad, 0);
      chk(tick_bad == 0, "R7 chip without tick", tick_bad, 0);
      chk(n == total, "R4 chip count", n, total);
      chk(seen_done, "R10 done seen", int'(seen_done), 1);
      chk(underflow === exp_uf, "R9 underflow flag", int'(underflow), int'(exp_uf));
      @(negedge clk);
      chk(done === 1'b0, "R10 done one cycle", int'(done), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(busy === 0 && done === 0 && underflow === 0 && chip_valid === 0 &&
          chip_bit === 0 && chip_i === 0 && chip_q === 0 && fifo_full === 0,
          "R11 reset state", int'({busy, done, underflow, chip_valid, chip_bit, chip_i, chip_q, fifo_full}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0 && fifo_full === 1'b0, "R11 idle after reset", int'({busy, fifo_full}), 0);

      // Vector table walk
      for (int v = 0; v < NVEC; v++) begin
         head();
         exp_b.push_back(VEC[v][0]);
         push(VEC[v][0]);
         for (int i = 0; i < VEC[v][0]; i++) begin
            int b;
            b = (VEC[v][1] + 37 * i) & 255;
            exp_b.push_back(b);
            push(b);
         end
         run_frame(VEC[v][2], VEC[v][3], 1'b0, $sformatf("vec%0d", v));
      end

      // R1: fill buffer, extra write dropped
      head();
      exp_b.push_back(127);
      push(127);
      for (int i = 1; i < 128; i++) begin
         exp_b.push_back((i * 29) & 255);
         push((i * 29) & 255);
      end
      chk(fifo_full === 1'b1, "R1 full at 128", int'(fifo_full), 1);
      push(8'h55);
      chk(fifo_full === 1'b1, "R1 full after dropped write", int'(fifo_full), 1);
      run_frame(1, -1, 1'b0, "full");
      chk(fifo_full === 1'b0, "R1 not full after drain", int'(fifo_full), 0);

      // R9 / R1: empty buffer, frame stops after delimiter
      head();
      run_frame(1, -1, 1'b1, "empty");
      repeat (3) @(negedge clk);
      chk(underflow === 1'b1, "R9 underflow sticky", int'(underflow), 1);

      // R9: payload runs out
      head();
      exp_b.push_back(3);
      exp_b.push_back(8'h9B);
      push(3);
      push(8'h9B);
      run_frame(2, -1, 1'b1, "short");

      // R7: no chip without tick while busy
      head();
      exp_b.push_back(0);
      push(0);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) begin
         @(negedge clk);
         chk(chip_valid === 1'b0 && busy === 1'b1, "R7 stalled without tick", int'({chip_valid, busy}), 1);
      end
      exp_b.delete();
      for (int i = 0; i < 4; i++) exp_b.push_back(0);
      exp_b.push_back(8'hA7);
      exp_b.push_back(0);
      begin
         int n = 0;
         for (int cyc = 0; cyc < 500; cyc++) begin
            chip_en = 1'b1;
            @(negedge clk);
            if (chip_valid) n++;
            if (done) break;
         end
         chip_en = 1'b0;
         chk(n == 384, "R4 zero-length frame after stall", n, 384);
      end

      ended = 1'b1;
      summary();
      $finish;
   end
endmodule